// File: doc/BRIEF.md
# Masked Pin Port Multiplexer

This block owns a port of up to 32 I/O pins and decides, pin by pin, who drives each pad. A pin is either under software control, where a stored direction bit and a stored output bit drive it, or it is handed to one of several on-chip peripheral functions, which then supply the pin's output value and output enable. The block also holds each pin's pull mode, open-drain setting and drive strength. It produces the pad-ring controls and returns the pad inputs through a two-stage synchronizer.

Configuration arrives as single-cycle commands on a valid-qualified bus. Each command carries an opcode, a pin mask, a function number and a flags word. The command is applied at one clock edge to the pins whose mask bit is set, and no other pin changes. The parameter `FULL` selects between two builds. The full build offers four peripheral functions per pin and supports every pull mode and the drive strength. The reduced build offers two functions, remaps the pull modes it cannot provide, and has no drive strength.

Top module: `pinmux_port`

## Requirements
- R1: Opcode 0 puts the masked pins under software control. Opcode 1 hands them to the peripheral function numbered by `cmd_func`. A peripheral-owned pin p with function f takes its value from `per_out[f*NPINS+p]` and its enable from `per_oe[f*NPINS+p]`.
- R2: A command changes only the pins whose `cmd_mask` bit is 1. A mask of zero changes nothing.
- R3: Flags bits [1:0] request a direction: 01 means input, 10 means output, and 00 or 11 leaves the direction as it is. Only opcode 0 applies this field. Opcode 1 leaves the stored direction unchanged.
- R4: Flags bits [3:2] request an output level: 01 means low and 10 means high. The level is loaded only by an opcode 0 command that also requests output direction.
- R5: Flags bits [5:4] select the pull mode, applied by opcodes 0 and 1: 00 none, 01 pull-up (`pad_pu`), 10 pull-down (`pad_pd`), 11 bus-keeper (`pad_keep`). At most one of the three pull outputs is high for a pin.
- R6: In the reduced build (`FULL`=0), a pull-down request gives no pull and a bus-keeper request gives pull-up.
- R7: Flags bit 6 sets open-drain, applied by opcodes 0 and 1. On an open-drain pin, `pad_out` is 0 and the driver is enabled only while the source value is 0. A source value of 1 releases the pin.
- R8: Flags bits [8:7] set the drive strength (0 min to 3 max), output on `pad_drv[2p+1:2p]`. The full build stores it. The reduced build always outputs 0.
- R9: Opcode 2 sets and opcode 3 clears the stored output bit of the masked pins, whatever mode they are in. The stored bit of a peripheral-owned pin does not reach the pad, and it drives the pad again once the pin returns to software control.
- R10: After reset, every pin is a software input with no pull, open-drain off, drive 0, the output register cleared and `pin_val` at 0.
- R11: `pin_val` equals `pad_in` as it was two clock edges earlier.
- R12: The reduced build uses only `cmd_func[0]`, so function 2 selects function 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, applied at this edge |
| cmd_op | input | 2 | 0 software, 1 peripheral, 2 set output, 3 clear output |
| cmd_mask | input | NPINS | Pins the command acts on |
| cmd_func | input | 2 | Peripheral function number for opcode 1 |
| cmd_flags | input | 9 | Direction, level, pull, open-drain and drive fields |
| per_out | input | NFUNC*NPINS | Per-function, per-pin output values |
| per_oe | input | NFUNC*NPINS | Per-function, per-pin output enables |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad driver enable |
| pad_pu | output | NPINS | Pull-up enable |
| pad_pd | output | NPINS | Pull-down enable |
| pad_keep | output | NPINS | Bus-keeper enable |
| pad_drv | output | 2*NPINS | Drive strength, two bits per pin |
| pin_val | output | NPINS | Synchronized pad inputs |

## Verification
Two things can land in the same cycle: a select command that hands a pin to a peripheral, and a change in that peripheral's own output value for the pin. The bench changes the peripheral's value on the same clock edge that carries the select command. It then expects the pad to show the new value straight after that edge, with no stale software value and no extra cycle. The same collision appears when set or clear commands hit peripheral-owned pins. The bench judges this by returning those pins to software control and reading back the stored level at the pad.

// File: rtl/pinmux_port.sv
module pinmux_port #(
  parameter int NPINS = 32,
  parameter bit FULL  = 1'b1,
  localparam int NFUNC  = FULL ? 4 : 2,
  localparam int FSEL_W = FULL ? 2 : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [NPINS-1:0]       cmd_mask,
  input  logic [1:0]             cmd_func,
  input  logic [8:0]             cmd_flags,
  input  logic [NFUNC*NPINS-1:0] per_out,
  input  logic [NFUNC*NPINS-1:0] per_oe,
  input  logic [NPINS-1:0]       pad_in,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_oe,
  output logic [NPINS-1:0]       pad_pu,
  output logic [NPINS-1:0]       pad_pd,
  output logic [NPINS-1:0]       pad_keep,
  output logic [2*NPINS-1:0]     pad_drv,
  output logic [NPINS-1:0]       pin_val
);

  localparam logic [1:0] OP_SW  = 2'd0;
  localparam logic [1:0] OP_PER = 2'd1;
  localparam logic [1:0] OP_SET = 2'd2;
  localparam logic [1:0] OP_CLR = 2'd3;

  logic [NPINS-1:0]  sw_q, dir_q, lvl_q, od_q, pu_q, pd_q, kp_q;
  logic [FSEL_W-1:0] fsel_q [NPINS];
  logic [NPINS-1:0]  sync1_q, sync2_q;

  wire do_sw  = cmd_valid && (cmd_op == OP_SW);
  wire do_per = cmd_valid && (cmd_op == OP_PER);
  wire do_set = cmd_valid && (cmd_op == OP_SET);
  wire do_clr = cmd_valid && (cmd_op == OP_CLR);

  wire want_out = cmd_flags[1:0] == 2'b10;
  wire want_in  = cmd_flags[1:0] == 2'b01;
  wire lvl_lo   = want_out && (cmd_flags[3:2] == 2'b01);
  wire lvl_hi   = want_out && (cmd_flags[3:2] == 2'b10);

  logic [1:0] pull_req;
  always_comb begin
    pull_req = cmd_flags[5:4];
    if (!FULL) begin
      if (pull_req == 2'b10) pull_req = 2'b00;
      else if (pull_req == 2'b11) pull_req = 2'b01;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= '1;
      dir_q <= '0;
      lvl_q <= '0;
      od_q  <= '0;
      pu_q  <= '0;
      pd_q  <= '0;
      kp_q  <= '0;
      for (int p = 0; p < NPINS; p++) fsel_q[p] <= '0;
    end else begin
      for (int p = 0; p < NPINS; p++) begin
        if (cmd_mask[p]) begin
          if (do_sw) begin
            sw_q[p] <= 1'b1;
            if (want_out)     dir_q[p] <= 1'b1;
            else if (want_in) dir_q[p] <= 1'b0;
            if (lvl_lo)       lvl_q[p] <= 1'b0;
            else if (lvl_hi)  lvl_q[p] <= 1'b1;
          end
          if (do_per) begin
            sw_q[p]   <= 1'b0;
            fsel_q[p] <= cmd_func[FSEL_W-1:0];
          end
          if (do_sw || do_per) begin
            od_q[p] <= cmd_flags[6];
            pu_q[p] <= pull_req == 2'b01;
            pd_q[p] <= pull_req == 2'b10;
            kp_q[p] <= pull_req == 2'b11;
          end
          if (do_set) lvl_q[p] <= 1'b1;
          if (do_clr) lvl_q[p] <= 1'b0;
        end
      end
    end
  end

  generate
    if (FULL) begin : g_drive
      logic [1:0] drv_q [NPINS];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int p = 0; p < NPINS; p++) drv_q[p] <= 2'd0;
        end else if (do_sw || do_per) begin
          for (int p = 0; p < NPINS; p++)
            if (cmd_mask[p]) drv_q[p] <= cmd_flags[8:7];
        end
      end
      for (genvar p = 0; p < NPINS; p++) begin : g_drv_pin
        assign pad_drv[2*p +: 2] = drv_q[p];
      end
    end else begin : g_nodrive
      assign pad_drv = '0;
    end
  endgenerate

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      wire src_out = sw_q[p] ? lvl_q[p] : per_out[int'(fsel_q[p])*NPINS + p];
      wire src_oe  = sw_q[p] ? dir_q[p] : per_oe[int'(fsel_q[p])*NPINS + p];
      assign pad_out[p] = src_out & ~od_q[p];
      assign pad_oe[p]  = od_q[p] ? (src_oe & ~src_out) : src_oe;
    end
  endgenerate

  assign pad_pu   = pu_q;
  assign pad_pd   = pd_q;
  assign pad_keep = kp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end
  assign pin_val = sync2_q;

  assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((((sw_q ^ $past(sw_q)) | (dir_q ^ $past(dir_q)) | (lvl_q ^ $past(lvl_q))
               | (od_q ^ $past(od_q)) | (pu_q ^ $past(pu_q)))
              & ~($past(cmd_valid) ? $past(cmd_mask) : '0)) == '0));

  assert_per_keeps_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_per |=> (dir_q == $past(dir_q)));

  assert_pull_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_pd) | (pad_pu & pad_keep) | (pad_pd & pad_keep)) == '0);

  assert_od_never_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (od_q & pad_oe & pad_out) == '0);

  assert_set_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_set |=> ((lvl_q & $past(cmd_mask)) == $past(cmd_mask)));

  assert_sync_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (pin_val == $past(pad_in, 2)));

  generate
    if (!FULL) begin : g_lite_chk
      assert_no_pulldown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pd == '0 && pad_keep == '0);
    end
  endgenerate

endmodule

// File: tb/pinmux_port_test.sv
module pinmux_port_test;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] mask;
    logic [1:0]  func;
    logic [8:0]  flags;
    logic [31:0] eout;
    logic [31:0] eoe;
    logic [31:0] epu;
    logic [31:0] epd;
    logic [31:0] ekp;
  } row_t;

  localparam int NROWS = 11;
  localparam row_t TBL [NROWS] = '{
    '{2'd0, 32'h0000_00FF, 2'd0, 9'h00A, 32'h0000_00FF, 32'h0000_00FF, 32'h0, 32'h0, 32'h0},
    '{2'd0, 32'h0000_000F, 2'd0, 9'h019, 32'h0000_00FF, 32'h0000_00F0, 32'h0F, 32'h0, 32'h0},
    '{2'd1, 32'h0000_FF00, 2'd0, 9'h020, 32'h0000_AAFF, 32'h0000_FFF0, 32'h0F, 32'hFF00, 32'h0},
    '{2'd1, 32'hFFFF_0000, 2'd2, 9'h002, 32'h1234_AAFF, 32'h00FF_FFF0, 32'h0F, 32'hFF00, 32'h0},
    '{2'd0, 32'h0000_0F00, 2'd0, 9'h052, 32'h1234_A0FF, 32'h00FF_FFF0, 32'h0F0F, 32'hF000, 32'h0},
    '{2'd2, 32'h0000_0300, 2'd0, 9'h000, 32'h1234_A0FF, 32'h00FF_FCF0, 32'h0F0F, 32'hF000, 32'h0},
    '{2'd1, 32'h0000_00F0, 2'd3, 9'h030, 32'h1234_A0FF, 32'h00FF_FCF0, 32'h0F0F, 32'hF000, 32'hF0},
    '{2'd3, 32'h0000_00FF, 2'd0, 9'h000, 32'h1234_A0F0, 32'h00FF_FCF0, 32'h0F0F, 32'hF000, 32'hF0},
    '{2'd0, 32'h0000_0000, 2'd0, 9'h00A, 32'h1234_A0F0, 32'h00FF_FCF0, 32'h0F0F, 32'hF000, 32'hF0},
    '{2'd1, 32'h0000_0001, 2'd1, 9'h040, 32'h1234_A0F0, 32'h00FF_FCF0, 32'h0F0E, 32'hF000, 32'hF0},
    '{2'd0, 32'h0001_0000, 2'd0, 9'h000, 32'h1234_A0F0, 32'h00FE_FCF0, 32'h0F0E, 32'hF000, 32'hF0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [31:0] cmd_mask = '0;
  logic [1:0] cmd_func = '0;
  logic [8:0] cmd_flags = '0;
  logic [127:0] per_out = {32'hFFFF_FFFF, 32'h1234_5678, 32'h0F0F_0F0F, 32'hAAAA_AAAA};
  logic [127:0] per_oe  = {32'hF0F0_F0F0, 32'h00FF_00FF, 32'hFFFF_0000, 32'hFFFF_FFFF};
  logic [31:0] pad_in = '0;

  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd, pad_keep, pin_val;
  logic [63:0] pad_drv;
  logic [31:0] l_out, l_oe, l_pu, l_pd, l_keep, l_val;
  logic [63:0] l_drv;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pinmux_port #(.NPINS(32), .FULL(1'b1)) uut (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_mask, .cmd_func, .cmd_flags,
    .per_out, .per_oe, .pad_in, .pad_out, .pad_oe, .pad_pu, .pad_pd,
    .pad_keep, .pad_drv, .pin_val);

  pinmux_port #(.NPINS(32), .FULL(1'b0)) uut_lite (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_mask, .cmd_func, .cmd_flags,
    .per_out(per_out[63:0]), .per_oe(per_oe[63:0]), .pad_in,
    .pad_out(l_out), .pad_oe(l_oe), .pad_pu(l_pu), .pad_pd(l_pd),
    .pad_keep(l_keep), .pad_drv(l_drv), .pin_val(l_val));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] mask,
                       input logic [1:0] func, input logic [8:0] flags);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_mask  = mask;
    cmd_func  = func;
    cmd_flags = flags;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_mask  = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 pad_oe", {32'h0, pad_oe}, 64'h0);
    chk("R10 pad_out", {32'h0, pad_out}, 64'h0);
    chk("R10 pulls", {32'h0, pad_pu | pad_pd | pad_keep}, 64'h0);
    chk("R10 pad_drv", pad_drv, 64'h0);
    chk("R10 pin_val", {32'h0, pin_val}, 64'h0);

    // R1 R2 R3 R4 R5 R7 R9 table walk
    for (int i = 0; i < NROWS; i++) begin
      issue(TBL[i].op, TBL[i].mask, TBL[i].func, TBL[i].flags);
      chk($sformatf("R1 R2 row %0d pad_out", i), {32'h0, pad_out}, {32'h0, TBL[i].eout});
      chk($sformatf("R3 R7 row %0d pad_oe", i), {32'h0, pad_oe}, {32'h0, TBL[i].eoe});
      chk($sformatf("R5 row %0d pad_pu", i), {32'h0, pad_pu}, {32'h0, TBL[i].epu});
      chk($sformatf("R5 row %0d pad_pd", i), {32'h0, pad_pd}, {32'h0, TBL[i].epd});
      chk($sformatf("R5 row %0d pad_keep", i), {32'h0, pad_keep}, {32'h0, TBL[i].ekp});
    end

    // R9 stored level cleared while peripheral-owned shows once back in software mode
    issue(2'd0, 32'h0000_00F0, 2'd0, 9'h000);
    chk("R9 pad_out after return", {32'h0, pad_out}, {32'h0, 32'h1234_A000});
    chk("R9 pad_oe after return", {32'h0, pad_oe}, {32'h0, 32'h00FE_FCF0});

    // R6 reduced pull remap, R5 full pull modes
    issue(2'd0, 32'h0100_0000, 2'd0, 9'h020);
    chk("R5 full pull-down", {63'h0, pad_pd[24]}, 64'h1);
    chk("R6 lite pull-down dropped", {62'h0, l_pu[24], l_pd[24]}, 64'h0);
    issue(2'd0, 32'h0200_0000, 2'd0, 9'h030);
    chk("R5 full keeper", {62'h0, pad_keep[25], pad_pu[25]}, 64'h2);
    chk("R6 lite keeper as pull-up", {62'h0, l_keep[25], l_pu[25]}, 64'h1);

    // R8 drive strength
    issue(2'd0, 32'h0400_0000, 2'd0, 9'h180);
    chk("R8 full drive", {62'h0, pad_drv[53:52]}, 64'h3);
    chk("R8 lite drive ignored", l_drv, 64'h0);

    // R12 lite function bit 1 ignored; R1 full function 2
    issue(2'd1, 32'h0000_0040, 2'd2, 9'h000);
    chk("R1 full func2 pin6", {62'h0, pad_oe[6], pad_out[6]}, 64'h3);
    chk("R12 lite func0 pin6", {62'h0, l_oe[6], l_out[6]}, 64'h2);

    // R11 input synchronizer
    @(negedge clk);
    pad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("R11 after one edge", {32'h0, pin_val}, 64'h0);
    @(negedge clk);
    chk("R11 after two edges", {32'h0, pin_val}, {32'h0, 32'hDEAD_BEEF});

    // R1 select and peripheral value change on the same edge
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'd1;
    cmd_mask  = 32'h0010_0000;
    cmd_func  = 2'd0;
    cmd_flags = 9'h000;
    per_out[31:0] = 32'h5555_5555;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_mask  = '0;
    chk("R1 same-edge handover pin20", {62'h0, pad_oe[20], pad_out[20]}, 64'h3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule